// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. On each cycle that `op_valid` is high, it takes the accumulator, one operand byte, an already decoded operation code and the current flag byte, and it also takes two 16-bit register pairs. One clock later it presents the new accumulator value, the new flags and a 16-bit pair result, all held in registers. Upstream logic supplies the operands and decodes the instructions. The sequencer writes the results back.

Each operation class follows its own flag rule. The sum and difference groups rewrite every flag. The logic group forces the two carry flags to fixed values. Rotates and carry manipulation touch only the carry. The 16-bit pair add touches only the carry, and the pair increment and decrement leave the flags alone.

Flag byte layout, used on `flags_in` and `flg_out`: bit 0 carry (CY), bit 1 parity (P), bit 2 half carry (AC), bit 3 zero (Z), bit 4 sign (S).

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out`, `flg_out` and `wide_out` become zero and `res_valid` becomes 0.
- R2: An operation presented with `op_valid`=1 shows its result and `res_valid`=1 after exactly one clock edge. With `op_valid`=0, `res_valid` becomes 0 and all three result outputs keep their values.
- R3: Add (code 0) and add-with-carry (code 1) put A+B, or A+B+CY, modulo 256 into `acc_out`. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R4: Subtract (code 2) and subtract-with-borrow (code 3) put A-B, or A-B-CY, modulo 256 into `acc_out`. CY is set on a borrow out of the byte and AC is set on a borrow out of the low nibble.
- R5: For codes 0 to 9, Z=1 when the byte result is zero, S equals bit 7 of the result, and P=1 when the result has an even number of one bits.
- R6: Increment (code 4) and decrement (code 5) give A+1 and A-1 modulo 256. They set AC on a nibble carry or borrow, and CY keeps its input value.
- R7: Compare (code 6) leaves `acc_out` equal to A and sets the flags as a subtraction would. So CY=1 exactly when A<B unsigned, and Z=1 exactly when A==B.
- R8: AND (code 7) gives CY=0 and AC=1. OR (code 8) and XOR (code 9) give CY=0 and AC=0.
- R9: Rotate left (code 10) moves bit 7 to bit 0 and to CY. Rotate left through carry (code 11) shifts the old CY into bit 0 and bit 7 into CY. Rotate right through carry (code 12) shifts the old CY into bit 7 and bit 0 into CY. The other flags are unchanged.
- R10: Complement (code 13) gives ~A and leaves all flags unchanged. Complement-carry (code 14) inverts CY. Set-carry (code 15) sets CY to 1. Codes 14 and 15 leave A and the other flags unchanged.
- R11: Pair add (code 16) gives `wide_out` = HL+pair modulo 65536 and CY equal to the carry out of bit 15. A and the other flags are unchanged.
- R12: Pair increment (code 17) and pair decrement (code 18) give `wide_out` = pair+1 and pair-1 modulo 65536. A and all flags are unchanged.
- R13: For codes 0 to 15, `wide_out` takes the value of `hl_in`. Codes 19 to 31 pass A, the flags and HL through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Decoded operation code |
| acc_in | input | 8 | Accumulator value A |
| opnd_in | input | 8 | Operand byte B |
| flags_in | input | 5 | Current flag byte |
| hl_in | input | 16 | HL pair, first addend of the pair add |
| pair_in | input | 16 | Selected register pair |
| acc_out | output | 8 | New accumulator |
| flg_out | output | 5 | New flag byte |
| wide_out | output | 16 | 16-bit pair result |
| res_valid | output | 1 | Results updated on the last edge |

## Verification
The block keeps no state between operations apart from its output registers. A wrong internal value therefore appears on `acc_out`, `flg_out` or `wide_out` one edge after the operation that caused it. A wrong carry-in selection or a wrong nibble width shows up as a bad AC or CY on a vector whose low nibble sits at 0 or F. A wrong update mask shows up as a flag changing on an operation that should keep it, so each vector starts from random input flags. An output register that fails to hold can only be seen on idle cycles, and those are checked against the last value presented.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int FLAG_W = 5;
  localparam int FL_CY  = 0;
  localparam int FL_P   = 1;
  localparam int FL_AC  = 2;
  localparam int FL_Z   = 3;
  localparam int FL_S   = 4;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_INC = 5'd4,  OP_DEC = 5'd5,  OP_CMP = 5'd6,  OP_AND = 5'd7,
    OP_OR  = 5'd8,  OP_XOR = 5'd9,  OP_RLC = 5'd10, OP_RAL = 5'd11,
    OP_RAR = 5'd12, OP_CMA = 5'd13, OP_CMC = 5'd14, OP_STC = 5'd15,
    OP_DAD = 5'd16, OP_INX = 5'd17, OP_DCX = 5'd18
  } alu_op_e;
endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cy_in,
  output logic [DW-1:0] res,
  output logic          cy_out,
  output logic          ac_out
);
  localparam int HW = DW / 2;

  logic [DW-1:0] x;
  logic          cin;
  logic          sub;
  logic [DW:0]   full;
  logic [HW:0]   low;

  always_comb begin
    x   = b;
    cin = 1'b0;
    sub = 1'b0;
    case (op)
      OP_ADC: cin = cy_in;
      OP_SUB: sub = 1'b1;
      OP_SBB: begin sub = 1'b1; cin = cy_in; end
      OP_CMP: sub = 1'b1;
      OP_INC: x = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: begin x = {{(DW-1){1'b0}}, 1'b1}; sub = 1'b1; end
      default: ;
    endcase
    if (sub) begin
      full = {1'b0, a} - {1'b0, x} - (DW+1)'(cin);
      low  = {1'b0, a[HW-1:0]} - {1'b0, x[HW-1:0]} - (HW+1)'(cin);
    end else begin
      full = {1'b0, a} + {1'b0, x} + (DW+1)'(cin);
      low  = {1'b0, a[HW-1:0]} + {1'b0, x[HW-1:0]} + (HW+1)'(cin);
    end
    res    = full[DW-1:0];
    cy_out = full[DW];
    ac_out = low[HW];
  end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cy_in,
  output logic [DW-1:0] res,
  output logic          cy_out,
  output logic          ac_out
);
  always_comb begin
    res    = a;
    cy_out = cy_in;
    ac_out = 1'b0;
    case (op)
      OP_AND: begin res = a & b; cy_out = 1'b0; ac_out = 1'b1; end
      OP_OR:  begin res = a | b; cy_out = 1'b0; end
      OP_XOR: begin res = a ^ b; cy_out = 1'b0; end
      OP_RLC: begin res = {a[DW-2:0], a[DW-1]}; cy_out = a[DW-1]; end
      OP_RAL: begin res = {a[DW-2:0], cy_in};   cy_out = a[DW-1]; end
      OP_RAR: begin res = {cy_in, a[DW-1:1]};   cy_out = a[0];    end
      OP_CMA: res = ~a;
      OP_CMC: cy_out = ~cy_in;
      OP_STC: cy_out = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_wide.sv
`timescale 1ns/1ps
module alu8_wide
  import alu8_pkg::*;
#(
  parameter int WW = 16
) (
  input  alu_op_e       op,
  input  logic [WW-1:0] hl,
  input  logic [WW-1:0] pair,
  output logic [WW-1:0] res,
  output logic          cy_out
);
  logic [WW:0] sum;

  always_comb begin
    sum    = {1'b0, hl} + {1'b0, pair};
    res    = hl;
    cy_out = 1'b0;
    case (op)
      OP_DAD: begin res = sum[WW-1:0]; cy_out = sum[WW]; end
      OP_INX: res = pair + WW'(1);
      OP_DCX: res = pair - WW'(1);
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  parameter int WW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     opnd_in,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [WW-1:0]     hl_in,
  input  logic [WW-1:0]     pair_in,
  output logic [DW-1:0]     acc_out,
  output logic [FLAG_W-1:0] flg_out,
  output logic [WW-1:0]     wide_out,
  output logic              res_valid
);
  alu_op_e       op;
  logic [DW-1:0] ar_res, lg_res;
  logic          ar_cy, ar_ac, lg_cy, lg_ac, wd_cy;
  logic [WW-1:0] wd_res;

  logic [DW-1:0]     nxt_acc;
  logic [FLAG_W-1:0] nxt_fl;
  logic [WW-1:0]     nxt_wide;

  assign op = alu_op_e'(op_code);

  alu8_arith #(.DW(DW)) u_arith (
    .op(op), .a(acc_in), .b(opnd_in), .cy_in(flags_in[FL_CY]),
    .res(ar_res), .cy_out(ar_cy), .ac_out(ar_ac)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op(op), .a(acc_in), .b(opnd_in), .cy_in(flags_in[FL_CY]),
    .res(lg_res), .cy_out(lg_cy), .ac_out(lg_ac)
  );

  alu8_wide #(.WW(WW)) u_wide (
    .op(op), .hl(hl_in), .pair(pair_in), .res(wd_res), .cy_out(wd_cy)
  );

  function automatic logic [FLAG_W-1:0] make_flags(
    input logic [DW-1:0] r, input logic cy, input logic ac);
    logic [FLAG_W-1:0] f;
    f        = '0;
    f[FL_CY] = cy;
    f[FL_P]  = ~^r;
    f[FL_AC] = ac;
    f[FL_Z]  = (r == '0);
    f[FL_S]  = r[DW-1];
    return f;
  endfunction

  always_comb begin
    nxt_acc  = acc_in;
    nxt_fl   = flags_in;
    nxt_wide = hl_in;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        nxt_acc = ar_res;
        nxt_fl  = make_flags(ar_res, ar_cy, ar_ac);
      end
      OP_INC, OP_DEC: begin
        nxt_acc = ar_res;
        nxt_fl  = make_flags(ar_res, flags_in[FL_CY], ar_ac);
      end
      OP_CMP: nxt_fl = make_flags(ar_res, ar_cy, ar_ac);
      OP_AND, OP_OR, OP_XOR: begin
        nxt_acc = lg_res;
        nxt_fl  = make_flags(lg_res, lg_cy, lg_ac);
      end
      OP_RLC, OP_RAL, OP_RAR, OP_CMC, OP_STC: begin
        nxt_acc        = lg_res;
        nxt_fl[FL_CY]  = lg_cy;
      end
      OP_CMA: nxt_acc = lg_res;
      OP_DAD: begin
        nxt_wide      = wd_res;
        nxt_fl[FL_CY] = wd_cy;
      end
      OP_INX, OP_DCX: nxt_wide = wd_res;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out   <= '0;
      flg_out   <= '0;
      wide_out  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        acc_out  <= nxt_acc;
        flg_out  <= nxt_fl;
        wide_out <= nxt_wide;
      end
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  parameter int WW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [OP_W-1:0]   op_code,
  input logic [DW-1:0]     acc_in,
  input logic [DW-1:0]     opnd_in,
  input logic [FLAG_W-1:0] flags_in,
  input logic [WW-1:0]     hl_in,
  input logic [WW-1:0]     pair_in,
  input logic [DW-1:0]     acc_out,
  input logic [FLAG_W-1:0] flg_out,
  input logic [WW-1:0]     wide_out,
  input logic              res_valid
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid && $stable(acc_out) && $stable(flg_out) && $stable(wide_out));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R5
  add_zsp_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_ADD |=>
      flg_out[FL_Z] == (acc_out == '0) && flg_out[FL_S] == acc_out[DW-1] &&
      flg_out[FL_P] == ~^acc_out);

  // R6
  incdec_cy_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && (op_code == OP_INC || op_code == OP_DEC) |=>
      flg_out[FL_CY] == $past(flags_in[FL_CY]));

  // R7
  cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_CMP |=>
      acc_out == $past(acc_in) &&
      flg_out[FL_Z] == ($past(acc_in) == $past(opnd_in)) &&
      flg_out[FL_CY] == ($past(acc_in) < $past(opnd_in)));

  // R8
  and_force_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_AND |=> !flg_out[FL_CY] && flg_out[FL_AC]);

  // R11
  dad_acc_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_DAD |=> acc_out == $past(acc_in));

  // R12
  pair_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && (op_code == OP_INX || op_code == OP_DCX) |=>
      flg_out == $past(flags_in) && acc_out == $past(acc_in));
endmodule

bind alu8_core alu8_core_chk #(.DW(DW), .WW(WW)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
  .hl_in(hl_in), .pair_in(pair_in), .acc_out(acc_out),
  .flg_out(flg_out), .wide_out(wide_out), .res_valid(res_valid)
);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [7:0]  acc_in = '0, opnd_in = '0;
  logic [4:0]  flags_in = '0;
  logic [15:0] hl_in = '0, pair_in = '0;
  logic [7:0]  acc_out;
  logic [4:0]  flg_out;
  logic [15:0] wide_out;
  logic        res_valid;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .hl_in(hl_in), .pair_in(pair_in), .acc_out(acc_out),
    .flg_out(flg_out), .wide_out(wide_out), .res_valid(res_valid)
  );

  // flag layout: [0] CY, [1] P, [2] AC, [3] Z, [4] S
  function automatic logic [4:0] fl_of(input logic [7:0] r, input logic cy, input logic ac);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    return {r[7], r == 8'h00, ac, (ones % 2) == 0, cy};
  endfunction

  function automatic logic [28:0] model(input int op, input logic [7:0] a, input logic [7:0] b,
      input logic [4:0] f, input logic [15:0] hl, input logic [15:0] pr);
    logic [7:0] r = a;  logic [4:0] nf = f;  logic [15:0] w = hl;
    int c = f[0];  int s;  int n;
    case (op)
      0, 1: begin
        if (op == 0) c = 0;
        s = int'(a) + int'(b) + c;  n = int'(a[3:0]) + int'(b[3:0]) + c;
        r = s[7:0];  nf = fl_of(r, s > 255, n > 15);
      end
      2, 3, 6: begin
        if (op != 3) c = 0;
        s = int'(a) - int'(b) - c;  n = int'(a[3:0]) - int'(b[3:0]) - c;
        nf = fl_of(s[7:0], s < 0, n < 0);
        if (op != 6) r = s[7:0];
      end
      4: begin r = a + 8'd1; nf = fl_of(r, f[0], a[3:0] == 4'hF); end
      5: begin r = a - 8'd1; nf = fl_of(r, f[0], a[3:0] == 4'h0); end
      7: begin r = a & b; nf = fl_of(r, 1'b0, 1'b1); end
      8: begin r = a | b; nf = fl_of(r, 1'b0, 1'b0); end
      9: begin r = a ^ b; nf = fl_of(r, 1'b0, 1'b0); end
      10: begin r = {a[6:0], a[7]}; nf[0] = a[7]; end
      11: begin r = {a[6:0], f[0]}; nf[0] = a[7]; end
      12: begin r = {f[0], a[7:1]}; nf[0] = a[0]; end
      13: r = ~a;
      14: nf[0] = ~f[0];
      15: nf[0] = 1'b1;
      16: begin s = int'(hl) + int'(pr); w = s[15:0]; nf[0] = s > 65535; end
      17: w = pr + 16'd1;
      18: w = pr - 16'd1;
      default: ;
    endcase
    return {r, nf, w};
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1: return "R3/R5";
      2, 3: return "R4/R5";
      4, 5: return "R6/R5";
      6: return "R7/R5";
      7, 8, 9: return "R8/R5";
      10, 11, 12: return "R9";
      13, 14, 15: return "R10";
      16: return "R11";
      17, 18: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic apply(input int op, input logic [7:0] a, input logic [7:0] b,
      input logic [4:0] f, input logic [15:0] hl, input logic [15:0] pr);
    logic [28:0] exp;
    @(negedge clk);
    op_valid = 1'b1; op_code = 5'(op); acc_in = a; opnd_in = b;
    flags_in = f; hl_in = hl; pair_in = pr;
    exp = model(op, a, b, f, hl, pr);
    @(negedge clk);
    op_valid = 1'b0;
    vectors++;
    if ({acc_out, flg_out, wide_out} !== exp || res_valid !== 1'b1) begin
      misses++;
      $display("FAIL %s R2 op=%0d: got acc=%h fl=%b wide=%h v=%b, expected acc=%h fl=%b wide=%h v=1",
               req_of(op), op, acc_out, flg_out, wide_out, res_valid, exp[28:21], exp[20:16], exp[15:0]);
    end
  endtask

  task automatic idle_check();
    logic [28:0] held;
    @(negedge clk);
    held = {acc_out, flg_out, wide_out};
    op_valid = 1'b0; op_code = 5'($urandom_range(0, 18));
    acc_in = 8'($urandom); opnd_in = 8'($urandom); flags_in = 5'($urandom);
    @(negedge clk);
    vectors++;
    if ({acc_out, flg_out, wide_out} !== held || res_valid !== 1'b0) begin
      misses++;
      $display("FAIL R2 idle hold: got %h v=%b, expected %h v=0",
               {acc_out, flg_out, wide_out}, res_valid, held);
    end
  endtask

  initial begin
    #1000000;
    misses++;
    $display("FAIL R2 watchdog expired: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; op_valid = 1'b1; op_code = 5'd0; acc_in = 8'hFF; opnd_in = 8'h01;
    repeat (3) @(negedge clk);
    vectors++;
    // R1 reset state
    if ({acc_out, flg_out, wide_out} !== 29'd0 || res_valid !== 1'b0) begin
      misses++;
      $display("FAIL R1 reset: got %h v=%b, expected 0 v=0", {acc_out, flg_out, wide_out}, res_valid);
    end
    op_valid = 1'b0;
    rst = 1'b0;

    // directed corners
    apply(0, 8'hFF, 8'h01, 5'b00000, 16'h1234, 16'h0000); // R3 wrap to zero
    apply(0, 8'h0F, 8'h01, 5'b00001, 16'h1234, 16'h0000); // R3 nibble carry
    apply(1, 8'hFE, 8'h01, 5'b00001, 16'h0000, 16'h0000); // R3 carry in
    apply(2, 8'h00, 8'h01, 5'b00000, 16'h0000, 16'h0000); // R4 borrow
    apply(3, 8'h10, 8'h0F, 5'b00001, 16'h0000, 16'h0000); // R4 borrow in
    apply(4, 8'hFF, 8'h00, 5'b00001, 16'h0000, 16'h0000); // R6 keep CY
    apply(5, 8'h00, 8'h00, 5'b00000, 16'h0000, 16'h0000); // R6 nibble borrow
    apply(6, 8'h42, 8'h42, 5'b00001, 16'h0000, 16'h0000); // R7 equal
    apply(6, 8'h41, 8'h42, 5'b00000, 16'h0000, 16'h0000); // R7 less
    apply(7, 8'hF0, 8'h0F, 5'b00001, 16'h0000, 16'h0000); // R8 and
    apply(9, 8'hAA, 8'hAA, 5'b00101, 16'h0000, 16'h0000); // R8 xor
    apply(10, 8'h80, 8'h00, 5'b11110, 16'h0000, 16'h0000); // R9
    apply(11, 8'h01, 8'h00, 5'b00001, 16'h0000, 16'h0000); // R9
    apply(12, 8'h01, 8'h00, 5'b00000, 16'h0000, 16'h0000); // R9
    apply(13, 8'h5A, 8'h00, 5'b10101, 16'h0000, 16'h0000); // R10
    apply(14, 8'h5A, 8'h00, 5'b01010, 16'h0000, 16'h0000); // R10
    apply(15, 8'h5A, 8'h00, 5'b01010, 16'h0000, 16'h0000); // R10
    apply(16, 8'h33, 8'h00, 5'b11110, 16'hFFFF, 16'h0001); // R11
    apply(17, 8'h33, 8'h00, 5'b10101, 16'h0000, 16'hFFFF); // R12
    apply(18, 8'h33, 8'h00, 5'b01010, 16'h0000, 16'h0000); // R12
    apply(31, 8'h77, 8'h11, 5'b10011, 16'hBEEF, 16'h1111); // R13
    idle_check();                                           // R2

    for (int k = 0; k < 3000; k++) begin
      apply(int'($urandom_range(0, 31)), 8'($urandom), 8'($urandom), 5'($urandom),
            16'($urandom), 16'($urandom));
      if (k % 16 == 0) idle_check();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule